// File: doc/BRIEF.md
# Pad Multiplexer with Write-Time Conflict Guard

This block sits between a group of I/O pads and the peripherals of a small SoC. Each pad has one configuration word. A 2-bit function code in that word picks which of four peripheral signals the pad carries. The same word also holds the pad's direction, pull resistor setting and drive strength. These electrical settings live in their own fields, and the function code never changes them.

In the outgoing direction, each pad drives the output of the peripheral signal it selects. In the incoming direction, each peripheral input receives the pad that claims it. A peripheral input that no pad claims reads 0.

Some peripheral signals can be reached from two different pads. A guard on the register write path refuses any write that would let two pads claim the same signal. A refused write leaves every register untouched and raises a sticky error flag. Software clears that flag by writing 1 to it. Because of the guard, the routing logic never has to settle a contention.

Function code 1 is a grouped bidirectional bus. On any pad set to code 1, the output enable comes from one shared peripheral enable bit. On every other pad, the output enable comes from the direction field.

Top module: `pinmux_top`

## Requirements
- R1: After reset every pad word reads 0: function 0, input, no pull, drive 0. The status word reads 0, and every padOe, padPullUp and padPullDn bit is 0.
- R2: The word of pad p is at address p. Writing it stores, and reading it returns, these fields: bits [1:0] function code, bit 2 direction (1 = output), bits [4:3] pull (bit 3 = pull-up, bit 4 = pull-down), bits [6:5] drive strength. Bit 7 reads 0.
- R3: Pad p with function code c drives padOut[p] from perOut[k]. With N pads, k is: p for code 0; N+p for code 1; 2N+p/2 for code 2; 2N+N/2+(p mod N/2) for code 3.
- R4: padOe[p] equals busOe when the function code of pad p is 1. For any other code it equals the direction bit. A write that only changes the function code leaves the stored direction as written.
- R5: padPullUp[p], padPullDn[p] and padDrive[2p+1:2p] follow the pull and drive fields of pad p, whatever function code is selected.
- R6: perIn[k] equals padIn of the pad whose code maps to signal k, using the mapping of R3. If no pad maps to k, perIn[k] is 0. If several pads did map to k, the lowest-numbered pad would win.
- R7: A pad write is refused if its function code maps to the same signal as the current code of any other pad. A refused write leaves all pad words unchanged and sets the error flag.
- R8: A pad write with both pull bits set (pull field 11) is refused in the same way.
- R9: The error flag is bit 0 of the status word at address N. It stays set until a write to address N with data bit 0 = 1 clears it. A write there with bit 0 = 0 has no effect.
- R10: At no time do two pads hold function codes that map to the same signal.
- R11: Writes to addresses above N change nothing. Reads from those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | AW | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | AW | Read address |
| rdData | output | 8 | Read data (combinational) |
| perOut | input | 3N | Peripheral output signals |
| busOe | input | 1 | Shared output enable of the bidirectional bus function |
| perIn | output | 3N | Peripheral input signals routed from the pads |
| padIn | input | N | Values received at the pads |
| padOut | output | N | Values driven to the pads |
| padOe | output | N | Pad output enables |
| padPullUp | output | N | Pull-up enables |
| padPullDn | output | N | Pull-down enables |
| padDrive | output | 2N | Drive strength, 2 bits per pad |

## Verification
The bench goes after four corner cases:

- **Two pads sharing a signal.** Pads that share a signal under code 2 (neighbours) or under code 3 (half the array apart) are written into collision. A guard that compared raw codes, or that compared a pad with itself, would either let a short through or refuse a harmless rewrite.
- **The clear-on-1 status bit.** Writing 0 must leave the flag set, and a refused write must not half-update the pad word.
- **Pull field 11 and unused addresses.** A pull field of 11 must be refused. Writes beyond the status word must not alias onto a pad's register.
- **Output enable on the bus function.** The bench toggles busOe while pads sit on code 1 and on other codes. A design that tied the output enable to the function code alone, or ignored busOe, would show the wrong padOe.

Random writes then keep probing for duplicate claims, and the bench checks the readback for uniqueness after every write.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

  // Per-pad configuration word, laid out as seen on the register port.
  typedef struct packed {
    logic [1:0] drive;
    logic [1:0] pull;   // bit0 pull-up, bit1 pull-down
    logic       dir;    // 1 = output
    logic [1:0] sel;
  } padCfg_t;

  // Strobes from the write guard to the datapath.
  typedef struct packed {
    logic cfgWe;
    logic errSet;
    logic errClr;
  } ctrlStrobe_t;

  localparam logic [1:0] SEL_BUS = 2'd1;

  // Peripheral signal index reached by a pad under a function code.
  function automatic int sigOf(int nPads, int pad, logic [1:0] code);
    case (code)
      2'd0:    return pad;
      2'd1:    return nPads + pad;
      2'd2:    return 2 * nPads + pad / 2;
      default: return 2 * nPads + nPads / 2 + pad % (nPads / 2);
    endcase
  endfunction

endpackage

// File: rtl/pinmux_guard.sv
module pinmux_guard
  import pinmux_pkg::*;
#(
  parameter int NUM_PADS = 8,
  parameter int AW = 4
) (
  input  logic                         wrEn,
  input  logic [AW-1:0]                wrAddr,
  input  logic [7:0]                   wrData,
  input  padCfg_t [NUM_PADS-1:0]       cfgQ,
  output ctrlStrobe_t                  strobe
);

  localparam logic [AW-1:0] STAT_ADDR = AW'(NUM_PADS);

  logic clash;
  logic badPull;
  logic isPad;
  logic isStat;

  always_comb begin
    clash = 1'b0;
    for (int p = 0; p < NUM_PADS; p++) begin
      if (AW'(p) != wrAddr &&
          sigOf(NUM_PADS, p, cfgQ[p].sel) == sigOf(NUM_PADS, int'(wrAddr), wrData[1:0]))
        clash = 1'b1;
    end
  end

  assign badPull = (wrData[4:3] == 2'b11);
  assign isPad   = (wrAddr < STAT_ADDR);
  assign isStat  = (wrAddr == STAT_ADDR);

  assign strobe.cfgWe  = wrEn && isPad && !clash && !badPull;
  assign strobe.errSet = wrEn && isPad && (clash || badPull);
  assign strobe.errClr = wrEn && isStat && wrData[0];

endmodule

// File: rtl/pinmux_path.sv
module pinmux_path
  import pinmux_pkg::*;
#(
  parameter int NUM_PADS = 8,
  parameter int NUM_SIGS = 24,
  parameter int AW = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             strobe,
  input  logic [AW-1:0]           wrAddr,
  input  logic [7:0]              wrData,
  input  logic [AW-1:0]           rdAddr,
  output logic [7:0]              rdData,
  output padCfg_t [NUM_PADS-1:0]  cfgQ,
  output logic                    errQ,
  input  logic [NUM_SIGS-1:0]     perOut,
  input  logic                    busOe,
  output logic [NUM_SIGS-1:0]     perIn,
  input  logic [NUM_PADS-1:0]     padIn,
  output logic [NUM_PADS-1:0]     padOut,
  output logic [NUM_PADS-1:0]     padOe,
  output logic [NUM_PADS-1:0]     padPullUp,
  output logic [NUM_PADS-1:0]     padPullDn,
  output logic [2*NUM_PADS-1:0]   padDrive
);

  localparam int PW = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;
  localparam logic [AW-1:0] STAT_ADDR = AW'(NUM_PADS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
      errQ <= 1'b0;
    end else begin
      if (strobe.cfgWe)
        cfgQ[wrAddr[PW-1:0]] <= padCfg_t'(wrData[6:0]);
      if (strobe.errSet)
        errQ <= 1'b1;
      else if (strobe.errClr)
        errQ <= 1'b0;
    end
  end

  always_comb begin
    if (rdAddr < STAT_ADDR)
      rdData = {1'b0, cfgQ[rdAddr[PW-1:0]]};
    else if (rdAddr == STAT_ADDR)
      rdData = {7'd0, errQ};
    else
      rdData = 8'd0;
  end

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    localparam int S0 = sigOf(NUM_PADS, p, 2'd0);
    localparam int S1 = sigOf(NUM_PADS, p, 2'd1);
    localparam int S2 = sigOf(NUM_PADS, p, 2'd2);
    localparam int S3 = sigOf(NUM_PADS, p, 2'd3);

    always_comb begin
      case (cfgQ[p].sel)
        2'd0:    padOut[p] = perOut[S0];
        2'd1:    padOut[p] = perOut[S1];
        2'd2:    padOut[p] = perOut[S2];
        default: padOut[p] = perOut[S3];
      endcase
    end

    assign padOe[p]            = (cfgQ[p].sel == SEL_BUS) ? busOe : cfgQ[p].dir;
    assign padPullUp[p]        = cfgQ[p].pull[0];
    assign padPullDn[p]        = cfgQ[p].pull[1];
    assign padDrive[2*p +: 2]  = cfgQ[p].drive;
  end

  // Inbound routing: walking downwards lets the lowest pad win as fallback.
  always_comb begin
    perIn = '0;
    for (int p = NUM_PADS - 1; p >= 0; p--)
      perIn[sigOf(NUM_PADS, p, cfgQ[p].sel)] = padIn[p];
  end

endmodule

// File: rtl/pinmux_top.sv
module pinmux_top
  import pinmux_pkg::*;
#(
  parameter int NUM_PADS = 8,
  localparam int NUM_SIGS = 3 * NUM_PADS,
  localparam int AW = $clog2(NUM_PADS + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [AW-1:0]          wrAddr,
  input  logic [7:0]             wrData,
  input  logic [AW-1:0]          rdAddr,
  output logic [7:0]             rdData,
  input  logic [NUM_SIGS-1:0]    perOut,
  input  logic                   busOe,
  output logic [NUM_SIGS-1:0]    perIn,
  input  logic [NUM_PADS-1:0]    padIn,
  output logic [NUM_PADS-1:0]    padOut,
  output logic [NUM_PADS-1:0]    padOe,
  output logic [NUM_PADS-1:0]    padPullUp,
  output logic [NUM_PADS-1:0]    padPullDn,
  output logic [2*NUM_PADS-1:0]  padDrive
);

  ctrlStrobe_t            strobe;
  padCfg_t [NUM_PADS-1:0] cfgQ;
  logic                   errQ;

  pinmux_guard #(.NUM_PADS(NUM_PADS), .AW(AW)) u_guard (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .cfgQ   (cfgQ),
    .strobe (strobe)
  );

  pinmux_path #(.NUM_PADS(NUM_PADS), .NUM_SIGS(NUM_SIGS), .AW(AW)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .cfgQ      (cfgQ),
    .errQ      (errQ),
    .perOut    (perOut),
    .busOe     (busOe),
    .perIn     (perIn),
    .padIn     (padIn),
    .padOut    (padOut),
    .padOe     (padOe),
    .padPullUp (padPullUp),
    .padPullDn (padPullDn),
    .padDrive  (padDrive)
  );

endmodule

// File: rtl/pinmux_checker.sv
module pinmux_checker
  import pinmux_pkg::*;
#(
  parameter int NUM_PADS = 8,
  parameter int AW = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   wrEn,
  input logic [AW-1:0]          wrAddr,
  input logic [7:0]             wrData,
  input padCfg_t [NUM_PADS-1:0] cfgQ,
  input logic                   errQ,
  input logic [NUM_PADS-1:0]    padPullUp,
  input logic [NUM_PADS-1:0]    padPullDn
);

  int sigQ [NUM_PADS];

  always_comb begin
    for (int p = 0; p < NUM_PADS; p++)
      sigQ[p] = sigOf(NUM_PADS, p, cfgQ[p].sel);
  end

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_i
    for (genvar j = i + 1; j < NUM_PADS; j++) begin : g_j
      a_r10_unique_claim: assert property (@(posedge clk) disable iff (!rstN)
        sigQ[i] != sigQ[j]);
    end

    a_r8_no_dual_pull: assert property (@(posedge clk) disable iff (!rstN)
      !(padPullUp[i] && padPullDn[i]));
  end

  a_r7_refused_holds: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errQ) |-> $stable(cfgQ));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errQ && !(wrEn && wrAddr == AW'(NUM_PADS) && wrData[0])) |=> errQ);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(cfgQ) && $stable(errQ)));

endmodule

bind pinmux_top pinmux_checker #(.NUM_PADS(NUM_PADS), .AW(AW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .wrData    (wrData),
  .cfgQ      (cfgQ),
  .errQ      (errQ),
  .padPullUp (padPullUp),
  .padPullDn (padPullDn)
);

// File: tb/pinmux_top_test.sv
module pinmux_top_test;

  localparam int N  = 8;
  localparam int NS = 3 * N;
  localparam int AW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [7:0] rdData;
  logic [NS-1:0] perOut = '0;
  logic busOe = 1'b0;
  logic [NS-1:0] perIn;
  logic [N-1:0] padIn = '0;
  logic [N-1:0] padOut, padOe, padPullUp, padPullDn;
  logic [2*N-1:0] padDrive;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [6:0] mCfg [N];
  logic mErr;

  always #2 clk = ~clk;

  pinmux_top #(.NUM_PADS(N)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .perOut(perOut), .busOe(busOe),
    .perIn(perIn), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .padPullUp(padPullUp), .padPullDn(padPullDn), .padDrive(padDrive)
  );

  function automatic int expSig(int p, logic [1:0] c);
    if (c == 2'd0) return p;
    if (c == 2'd1) return N + p;
    if (c == 2'd2) return 2 * N + p / 2;
    return 2 * N + N / 2 + p % (N / 2);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic modelWrite(int a, logic [7:0] d);
    bit clash = 1'b0;
    if (a < N) begin
      for (int p = 0; p < N; p++)
        if (p != a && expSig(p, mCfg[p][1:0]) == expSig(a, d[1:0])) clash = 1'b1;
      if (clash || d[4:3] == 2'b11) mErr = 1'b1;
      else mCfg[a] = d[6:0];
    end else if (a == N && d[0]) begin
      mErr = 1'b0;
    end
  endtask

  task automatic doWrite(int a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = AW'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic readCheck(int a, logic [7:0] exp, string req);
    rdAddr = AW'(a);
    #1;
    check(req, 32'(rdData), 32'(exp));
  endtask

  task automatic checkAll();
    logic [NS-1:0] ePerIn;
    logic [N-1:0] eOut, eOe, eUp, eDn;
    logic [2*N-1:0] eDrv;
    logic [7:0] rb [N];
    bit dup;
    perOut = NS'({$urandom, $urandom});
    padIn = N'($urandom);
    busOe = 1'($urandom);
    #1;
    ePerIn = '0;
    for (int p = 0; p < N; p++) begin
      eOut[p] = perOut[expSig(p, mCfg[p][1:0])];
      eOe[p] = (mCfg[p][1:0] == 2'd1) ? busOe : mCfg[p][2];
      eUp[p] = mCfg[p][3];
      eDn[p] = mCfg[p][4];
      eDrv[2*p +: 2] = mCfg[p][6:5];
    end
    for (int p = N - 1; p >= 0; p--) ePerIn[expSig(p, mCfg[p][1:0])] = padIn[p];
    check("R3 padOut", 32'(padOut), 32'(eOut));
    check("R4 padOe", 32'(padOe), 32'(eOe));
    check("R5 pulls", 32'({padPullUp, padPullDn}), 32'({eUp, eDn}));
    check("R5 drive", 32'(padDrive), 32'(eDrv));
    check("R6 perIn", 32'(perIn), 32'(ePerIn));
    for (int p = 0; p < N; p++) begin
      readCheck(p, {1'b0, mCfg[p]}, "R2 readback");
      rb[p] = rdData;
    end
    readCheck(N, {7'd0, mErr}, "R9 status");
    dup = 1'b0;
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        if (expSig(i, rb[i][1:0]) == expSig(j, rb[j][1:0])) dup = 1'b1;
    check("R10 unique claims", 32'(dup), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int p = 0; p < N; p++) mCfg[p] = '0;
    mErr = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 padOe", 32'(padOe), 32'd0);
    check("R1 pulls", 32'({padPullUp, padPullDn}), 32'd0);
    for (int p = 0; p <= N; p++) readCheck(p, 8'd0, "R1 reset word");
    checkAll();

    // R2 field layout: sel 2, output, pull-down, drive 1
    doWrite(3, 8'h36);
    readCheck(3, 8'h36, "R2 fields");
    checkAll();

    // R7 code 2 neighbours collide (pads 2,3 -> same signal)
    doWrite(2, 8'h02);
    readCheck(2, 8'h00, "R7 refused pad2 unchanged");
    readCheck(N, 8'h01, "R7 error set");
    // R9 write 0 keeps flag, write 1 clears
    doWrite(N, 8'h00);
    readCheck(N, 8'h01, "R9 write0 no effect");
    doWrite(N, 8'h01);
    readCheck(N, 8'h00, "R9 w1c clears");

    // R7 code 3 pads half apart collide (1 and 5)
    doWrite(1, 8'h03);
    readCheck(1, 8'h03, "R7 first claim accepted");
    doWrite(5, 8'h07);
    readCheck(5, 8'h00, "R7 code3 refused");
    readCheck(N, 8'h01, "R7 error after code3 clash");
    doWrite(N, 8'h01);

    // R7 rewriting a pad to its own signal is allowed
    doWrite(1, 8'h27);
    readCheck(1, 8'h27, "R7 self rewrite accepted");

    // R8 both pulls refused
    doWrite(6, 8'h18);
    readCheck(6, 8'h00, "R8 dual pull refused");
    readCheck(N, 8'h01, "R8 error set");
    doWrite(N, 8'h01);

    // R11 unused address
    doWrite(N + 3, 8'hFF);
    readCheck(N + 3, 8'h00, "R11 unused reads 0");
    checkAll();

    // R4 bus function: pad0 code1 dir=0, busOe drives oe
    doWrite(0, 8'h01);
    busOe = 1'b1; #1;
    check("R4 bus oe high", 32'(padOe[0]), 32'd1);
    busOe = 1'b0; #1;
    check("R4 bus oe low", 32'(padOe[0]), 32'd0);
    doWrite(0, 8'h04);
    busOe = 1'b1; #1;
    check("R4 dir oe", 32'(padOe[0]), 32'd1);
    readCheck(0, 8'h04, "R4 dir kept");
    checkAll();

    // Random writes with conflict pressure
    for (int it = 0; it < 400; it++) begin
      int a;
      logic [7:0] d;
      a = ($urandom % 8 == 0) ? (N + int'($urandom % 3)) : int'($urandom % N);
      d = 8'($urandom);
      if ($urandom % 3 != 0) d[1:0] = 2'd2 + 2'($urandom % 2);
      doWrite(a, d);
      checkAll();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule